// File: doc/BRIEF.md
# Learned Address Table Indirect Reader

This block gives a byte-wide register port read access to a table of 1024 learned station addresses. Software first writes a control byte that picks the learned table for reading and supplies the two high index bits. It then writes a trigger byte with the low eight index bits. The trigger starts a fetch from an internal single-port table memory. That memory may be shared with other logic, so the fetch waits for a grant.

The fetched entry and a count of occupied entries are joined into a 69-bit result word. Software reads this word as nine bytes, most significant byte first. A not-ready bit inside the word stays set while the fetch is pending, and software re-reads until the bit clears. The count field holds the occupancy minus one. A separate empty flag tells zero entries apart from one entry.

Top module: `addr_tbl_reader`

## Requirements
- R1: After reset, every result byte (addresses 112..120) reads 0 and `mem_req` is low.
- R2: A write to address 111 while the control byte (address 110) has bits 7..2 equal to 6'b000110 starts a fetch. From the next cycle `mem_req` is high and `mem_idx` = {control[1:0], trigger byte}.
- R3: A write to address 111 while control bits 7..2 hold any other code is ignored. No request is raised, bit 55 stays 0 and the result bytes keep their values.
- R4: While a fetch is pending, bit 55 (address 114 bit 7) reads 1 and all other result bits keep their previous values.
- R5: A cycle with `mem_req` and `mem_gnt` both high, and no new trigger, captures `mem_rdata`. From the next cycle `mem_req` is low and bit 55 reads 0.
- R6: Byte layout. Address 112 = {3'b000, empty, count[9:6]}. Address 113 = {count[5:0], stamp[1:0]}. Address 114 = {not-ready, port[2:0], filter[3:0]}. Addresses 115..120 hold the 48-bit address, most significant byte first. `mem_rdata` is {stamp[56:55], port[54:52], filter[51:48], address[47:0]}.
- R7: The count field is occupancy−1 and the empty flag is 0, so 1024 gives 0x3FF. Occupancy 0 gives count 0 with the empty flag set to 1.
- R8: Count and empty are taken from `occ_cnt` in the capture cycle, not in the trigger cycle.
- R9: A trigger write while a fetch is pending restarts it with the new index. A grant in the same cycle as that write is discarded.
- R10: Reads of any address outside 112..120 return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register address (read and write) |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Read data for `reg_addr`, combinational |
| mem_req | output | 1 | Fetch request to the table memory |
| mem_idx | output | 10 | Entry index being fetched |
| mem_gnt | input | 1 | Grant; `mem_rdata` valid in the same cycle |
| mem_rdata | input | 57 | Entry: stamp, port, filter, address |
| occ_cnt | input | 11 | Current number of valid entries, 0..1024 |

## Verification
A trigger write sampled at a rising edge shows up one edge later as `mem_req`, `mem_idx` and bit 55 set. A grant sampled at an edge changes the result bytes and clears bit 55 at that same edge. Reads decode combinationally, so they reflect the register state with no extra delay. The bench drives every input at a falling edge and samples at that falling edge or shortly after it. Each check therefore sees exactly one more rising edge per registered step. The occupancy input is moved during the wait, so the check shows which cycle it is sampled in.

// File: rtl/atr_pkg.sv
// Shared widths, register codes and the entry layout for the table reader.
// Assumes an 8-bit register bus and a 10-bit table index.
package atr_pkg;
    localparam int DATA_W    = 8;
    localparam int IDX_W     = 10;
    localparam int HI_W      = IDX_W - DATA_W;
    localparam int MAC_W     = 48;
    localparam int FID_W     = 4;
    localparam int PORT_W    = 3;
    localparam int STAMP_W   = 2;
    localparam int CNT_W     = IDX_W;
    localparam int OCC_W     = IDX_W + 1;
    localparam int ENT_W     = STAMP_W + PORT_W + FID_W + MAC_W;
    localparam int RES_W     = ENT_W + 1 + CNT_W + 1;
    localparam int RES_BYTES = (RES_W + DATA_W - 1) / DATA_W;
    localparam int PAD_W     = RES_BYTES * DATA_W - RES_W;
    localparam logic [DATA_W-HI_W-1:0] SEL_LEARN_RD = 6'b000110;

    typedef struct packed {
        logic [STAMP_W-1:0] stamp;
        logic [PORT_W-1:0]  port;
        logic [FID_W-1:0]   fid;
        logic [MAC_W-1:0]   mac;
    } entry_t;
endpackage

// File: rtl/atr_regs.sv
// Control byte storage and trigger decode.
// Assumes one register access per cycle; trigger valid only with the
// learned-table read code in the upper control bits.
module atr_regs
    import atr_pkg::*;
#(
    parameter logic [DATA_W-1:0] CTRL_ADDR = 8'd110,
    parameter logic [DATA_W-1:0] TRIG_ADDR = 8'd111
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [DATA_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic              trig_go,
    output logic [IDX_W-1:0]  trig_idx
);
    logic [DATA_W-1:0] ctrl_q;
    logic              sel_ok;

    // Hold the last control byte written.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ctrl_q <= '0;
        else if (reg_wr && reg_addr == CTRL_ADDR)
            ctrl_q <= reg_wdata;
    end

    // Decode the table-select code and form the trigger.
    always_comb begin
        sel_ok   = (ctrl_q[DATA_W-1:HI_W] == SEL_LEARN_RD);
        trig_go  = reg_wr && (reg_addr == TRIG_ADDR) && sel_ok;
        trig_idx = {ctrl_q[HI_W-1:0], reg_wdata};
    end
endmodule

// File: rtl/atr_enc.sv
// Turns an occupancy count into the N-1 count field plus empty flag.
// Assumes occupancy never exceeds the table depth.
module atr_enc
    import atr_pkg::*;
(
    input  logic [OCC_W-1:0] occ,
    output logic [CNT_W-1:0] cnt,
    output logic             empty
);
    // Zero occupancy sets empty; otherwise count is occupancy minus one.
    always_comb begin
        empty = (occ == '0);
        cnt   = empty ? '0 : (occ[CNT_W-1:0] - CNT_W'(1));
    end
endmodule

// File: rtl/atr_fetch.sv
// Fetch sequencer: holds the pending request and index, and captures the
// entry and encoded count on a grant. Assumes mem_rdata is valid with mem_gnt.
module atr_fetch
    import atr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             trig_go,
    input  logic [IDX_W-1:0] trig_idx,
    input  logic             mem_gnt,
    input  logic [ENT_W-1:0] mem_rdata,
    input  logic [CNT_W-1:0] enc_cnt,
    input  logic             enc_empty,
    output logic             pend_q,
    output logic [IDX_W-1:0] idx_q,
    output entry_t           ent_q,
    output logic [CNT_W-1:0] cnt_q,
    output logic             empty_q
);
    logic done;

    // Capture is allowed only when no new trigger overrides it.
    always_comb done = pend_q && mem_gnt && !trig_go;

    // Pending flag: set by trigger, cleared by a completed grant.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pend_q <= 1'b0;
        else if (trig_go)
            pend_q <= 1'b1;
        else if (done)
            pend_q <= 1'b0;
    end

    // Index register follows each accepted trigger.
    always_ff @(posedge clk) begin
        if (!rst_n)
            idx_q <= '0;
        else if (trig_go)
            idx_q <= trig_idx;
    end

    // Result capture of entry and encoded occupancy on completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ent_q   <= '0;
            cnt_q   <= '0;
            empty_q <= 1'b0;
        end else if (done) begin
            ent_q   <= entry_t'(mem_rdata);
            cnt_q   <= enc_cnt;
            empty_q <= enc_empty;
        end
    end
endmodule

// File: rtl/atr_rdmux.sv
// Byte readback: slices the result word MSB-first over consecutive
// addresses; any other address reads zero.
module atr_rdmux
    import atr_pkg::*;
#(
    parameter logic [DATA_W-1:0] RES_ADDR = 8'd112
) (
    input  logic [RES_W-1:0]  res_word,
    input  logic [DATA_W-1:0] reg_addr,
    output logic [DATA_W-1:0] reg_rdata
);
    logic [RES_BYTES*DATA_W-1:0] padded;
    logic [DATA_W-1:0]           slice [RES_BYTES];
    logic [DATA_W-1:0]           off;

    assign padded = {{PAD_W{1'b0}}, res_word};

    for (genvar b = 0; b < RES_BYTES; b++) begin : g_slice
        assign slice[b] = padded[DATA_W*(RES_BYTES-1-b) +: DATA_W];
    end

    // Select the addressed byte of the result window.
    always_comb begin
        off       = reg_addr - RES_ADDR;
        reg_rdata = '0;
        for (int b = 0; b < RES_BYTES; b++) begin
            if (reg_addr >= RES_ADDR && off == DATA_W'(b))
                reg_rdata = slice[b];
        end
    end
endmodule

// File: rtl/addr_tbl_reader.sv
// Top: indirect read-only window into the learned address table.
// Assumes a single master on the register bus and a memory that
// answers requests with a same-cycle grant and data.
module addr_tbl_reader
    import atr_pkg::*;
#(
    parameter logic [7:0] CTRL_ADDR = 8'd110,
    parameter logic [7:0] TRIG_ADDR = 8'd111,
    parameter logic [7:0] RES_ADDR  = 8'd112
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic [7:0]  reg_addr,
    input  logic [7:0]  reg_wdata,
    output logic [7:0]  reg_rdata,
    output logic        mem_req,
    output logic [9:0]  mem_idx,
    input  logic        mem_gnt,
    input  logic [56:0] mem_rdata,
    input  logic [10:0] occ_cnt
);
    logic             trig_go;
    logic [IDX_W-1:0] trig_idx;
    logic [CNT_W-1:0] enc_cnt;
    logic             enc_empty;
    logic             pend_q;
    logic [IDX_W-1:0] idx_q;
    entry_t           ent_q;
    logic [CNT_W-1:0] cnt_q;
    logic             empty_q;
    logic [RES_W-1:0] res_word;

    atr_regs #(.CTRL_ADDR(CTRL_ADDR), .TRIG_ADDR(TRIG_ADDR)) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .trig_go(trig_go), .trig_idx(trig_idx)
    );

    atr_enc u_enc (.occ(occ_cnt), .cnt(enc_cnt), .empty(enc_empty));

    atr_fetch u_fetch (
        .clk(clk), .rst_n(rst_n), .trig_go(trig_go), .trig_idx(trig_idx),
        .mem_gnt(mem_gnt), .mem_rdata(mem_rdata), .enc_cnt(enc_cnt),
        .enc_empty(enc_empty), .pend_q(pend_q), .idx_q(idx_q),
        .ent_q(ent_q), .cnt_q(cnt_q), .empty_q(empty_q)
    );

    // Assemble the 69-bit result word; not-ready sits at bit 55.
    assign res_word = {empty_q, cnt_q, ent_q.stamp, pend_q,
                       ent_q.port, ent_q.fid, ent_q.mac};

    atr_rdmux #(.RES_ADDR(RES_ADDR)) u_rdmux (
        .res_word(res_word), .reg_addr(reg_addr), .reg_rdata(reg_rdata)
    );

    assign mem_req = pend_q;
    assign mem_idx = idx_q;
endmodule

// File: rtl/atr_chk.sv
// Checker bound to the reader: tracks its own copy of the control byte
// and checks the request, hold and encoding rules over time.
module atr_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        reg_wr,
    input logic [7:0]  reg_addr,
    input logic [7:0]  reg_wdata,
    input logic        mem_req,
    input logic [9:0]  mem_idx,
    input logic        mem_gnt,
    input logic [68:0] res_word
);
    logic [7:0] ctl_sh;
    logic       trg_any;
    logic       trg_ok;

    // Shadow of the control byte, kept apart from the design.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ctl_sh <= '0;
        else if (reg_wr && reg_addr == 8'd110)
            ctl_sh <= reg_wdata;
    end

    assign trg_any = reg_wr && reg_addr == 8'd111;
    assign trg_ok  = trg_any && ctl_sh[7:2] == 6'b000110;

    p_trig_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
        trg_ok |=> mem_req && mem_idx == {$past(ctl_sh[1:0]), $past(reg_wdata)});

    p_ignore_r3: assert property (@(posedge clk) disable iff (!rst_n)
        trg_any && !trg_ok && !mem_req |=> !mem_req && !res_word[55]);

    p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_gnt |=> $stable(res_word[68:56]) && $stable(res_word[54:0]));

    p_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_gnt && !trg_ok |=> !mem_req && !res_word[55]);

    p_empty_r7: assert property (@(posedge clk) disable iff (!rst_n)
        res_word[68] |-> res_word[67:58] == 10'd0);

    p_idx_r9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !trg_ok |=> $stable(mem_idx));
endmodule

bind addr_tbl_reader atr_chk u_chk (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .mem_req(mem_req), .mem_idx(mem_idx),
    .mem_gnt(mem_gnt), .res_word(res_word)
);

// File: tb/addr_tbl_reader_test.sv
`timescale 1ns/1ps
module addr_tbl_reader_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [7:0]  reg_wdata = '0;
    logic [7:0]  reg_rdata;
    logic        mem_req;
    logic [9:0]  mem_idx;
    logic        mem_gnt = 1'b0;
    logic [56:0] mem_rdata;
    logic [10:0] occ_cnt = 11'd7;

    int n_chk = 0;
    int n_bad = 0;
    logic finished = 1'b0;

    always #2.5 clk = ~clk;

    addr_tbl_reader uut (.*);

    // Table model: entry content is a function of the index.
    function automatic logic [56:0] ent(input logic [9:0] i);
        return {i[1:0], 3'(i % 10'd5), i[3:0] ^ 4'hA, 16'hA5C3, 22'h0, i};
    endfunction

    assign mem_rdata = ent(mem_idx);

    // Expected 72-bit readback image (three zero pad bits on top).
    function automatic logic [71:0] expw(input logic [9:0] i, input logic [10:0] occ,
                                         input logic nr);
        logic [56:0] e;
        logic [9:0]  c;
        e = ent(i);
        c = (occ == 0) ? 10'd0 : 10'(occ - 11'd1);
        return {3'b000, occ == 0, c, e[56:55], nr, e[54:0]};
    endfunction

    localparam logic [71:0] NR_BIT = 72'd1 << 55;

    // idx[24:15], occupancy[14:4], grant wait[3:0]
    localparam logic [24:0] VEC [0:5] = '{
        {10'h000, 11'd0,    4'd0},
        {10'h3FF, 11'd1,    4'd3},
        {10'h155, 11'd2,    4'd1},
        {10'h2AA, 11'd1024, 4'd5},
        {10'h0C7, 11'd500,  4'd2},
        {10'h100, 11'd37,   4'd0}
    };

    task automatic chk(input string tag, input logic [71:0] got, input logic [71:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    // Read all nine result bytes within the low phase and compare.
    task automatic readall(input string tag, input logic [71:0] exp);
        logic [71:0] got;
        for (int k = 0; k < 9; k++) begin
            reg_addr = 8'(112 + k);
            #0.2;
            got[8*(8-k) +: 8] = reg_rdata;
        end
        chk(tag, got, exp);
    endtask

    task automatic grant_once(input logic [10:0] occ);
        @(negedge clk);
        mem_gnt = 1'b1; occ_cnt = occ;
        @(negedge clk);
        mem_gnt = 1'b0; occ_cnt = 11'd7;
    endtask

    initial begin
        logic [71:0] cur;
        cur = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk("R1 req", 72'(mem_req), 72'd0);
        readall("R1 bytes", 72'd0);

        // Vector walk: R2, R4, R5, R6, R7, R8
        for (int v = 0; v < 6; v++) begin
            logic [9:0]  vi;
            logic [10:0] vo;
            logic [3:0]  vw;
            {vi, vo, vw} = VEC[v];
            wr(8'd110, {6'b000110, vi[9:8]});
            wr(8'd111, vi[7:0]);
            chk("R2 req", 72'(mem_req), 72'd1);
            chk("R2 idx", 72'(mem_idx), 72'(vi));
            for (int w = 0; w < int'(vw); w++) begin
                readall("R4 hold", cur | NR_BIT);
                @(negedge clk);
            end
            grant_once(vo);
            chk("R5 req", 72'(mem_req), 72'd0);
            cur = expw(vi, vo, 1'b0);
            readall("R6/R7/R8 result", cur);
        end

        // R3: trigger with another select code is ignored
        wr(8'd110, 8'h10);
        wr(8'd111, 8'h33);
        chk("R3 req", 72'(mem_req), 72'd0);
        readall("R3 bytes", cur);
        grant_once(11'd99);
        readall("R3 after grant", cur);

        // R9: retrigger with a coincident grant restarts the fetch
        wr(8'd110, 8'h19);
        wr(8'd111, 8'h11);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 8'd111; reg_wdata = 8'h42;
        mem_gnt = 1'b1; occ_cnt = 11'd9;
        @(negedge clk);
        reg_wr = 1'b0; mem_gnt = 1'b0; occ_cnt = 11'd7;
        chk("R9 req", 72'(mem_req), 72'd1);
        chk("R9 idx", 72'(mem_idx), 72'h142);
        readall("R9 discard", cur | NR_BIT);
        grant_once(11'd300);
        cur = expw(10'h142, 11'd300, 1'b0);
        readall("R9 result", cur);

        // R10: addresses outside the window read zero
        reg_addr = 8'd50;  #0.2; chk("R10 a50",  72'(reg_rdata), 72'd0);
        reg_addr = 8'd110; #0.2; chk("R10 a110", 72'(reg_rdata), 72'd0);
        reg_addr = 8'd121; #0.2; chk("R10 a121", 72'(reg_rdata), 72'd0);

        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(5.0 * 200000);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog got=hung exp=done");
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end
endmodule